// File: doc/BRIEF.md
# Phase-Aligned Clock Divider Bank

This block takes one fast clock and produces up to eight divided clock-enable strobes from it. Each strobe is one cycle wide and repeats every N input cycles, where N is the ratio now active for that channel. Software never changes an active ratio directly. It writes a staged ratio per channel, selects the channels it wants to retune through two bit masks, and then issues a go command.

During a go, each selected channel finishes its current period with a final strobe and then waits silently. Once every selected channel is waiting, all of them take their staged ratio in the same cycle and restart from count zero together, so their strobes start out phase aligned. Channels that are not selected keep running on their old ratio throughout. A status bit reads busy from the go command until that common load.

Top module: `pdb_bank`

## Requirements
- R1: After reset every channel is disabled, so every strobe is high in every cycle. Status, staged ratios and both masks read 0.
- R2: A channel whose active ratio word has the enable bit (bit 15) set and field F asserts its strobe for one cycle out of every F+1 cycles.
- R3: A channel whose active enable bit is clear asserts its strobe in every cycle, whatever its field holds.
- R4: A ratio write changes only the staged copy, which reads back as bit 15 = enable and bits [RATIO_W-1:0] = field, with all other bits 0. The strobe is unaffected until a go.
- R5: Staged ratio words for channels 0..2 sit at byte offsets 0x18, 0x1C and 0x20. Channels 3..7 sit at 0x60, 0x64, 0x68, 0x6C and 0x70. The align mask is at 0x40 and the change mask at 0x44, with bit i for channel i.
- R6: Writing a word with bit 0 set to 0x38 starts a go. Bit 0 of 0x3C reads 1 from the cycle after that write until the new ratios are loaded.
- R7: A channel is selected when its bits are set in both masks. Each selected channel gives one final strobe and then stays silent. When all selected channels are silent, they load their staged ratios together and restart at count 0, so a strobe first appears F cycles after the load.
- R8: A channel that is not selected keeps its old ratio and phase through a go, even when its staged word differs.
- R9: When a go completes, the change mask clears to 0 and the align mask keeps its value.
- R10: While busy, writes to 0x38, 0x40 and 0x44 have no effect. No second go is queued.
- R11: A go that selects no channel completes on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that all channels divide |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| div_en | output | NUM_DIV | Per-channel divided clock-enable strobes |

## Verification
The assertions check on every cycle that the status bit follows the internal busy state, and that only selected channels wait, and only while a go is in progress. They also check that the masks stay frozen while busy, that the change mask is empty when busy falls, and that a go with nothing selected lasts a single cycle. The bench's scenarios are the only place that show the strobe periods, the common restart of two channels with different new ratios at their first coincident strobe, and the unchanged rhythm of unselected channels. They also show the address map and that a command issued while busy does not start a second go.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int EN_BIT = 15;

    localparam logic [ADDR_W-1:0] A_CMD   = 8'h38;
    localparam logic [ADDR_W-1:0] A_STAT  = 8'h3C;
    localparam logic [ADDR_W-1:0] A_ALIGN = 8'h40;
    localparam logic [ADDR_W-1:0] A_CHG   = 8'h44;

    // Channels 0..2 form a low block, channels 3 and up a high block.
    function automatic logic [ADDR_W-1:0] div_addr(input int idx);
        int a;
        a = (idx < 3) ? (8'h18 + 4 * idx) : (8'h60 + 4 * (idx - 3));
        return ADDR_W'(a);
    endfunction
endpackage

// File: rtl/pdb_div.sv
module pdb_div #(
    parameter int RATIO_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pend_en,
    input  logic [RATIO_W-1:0] pend_field,
    input  logic               sel,
    input  logic               load,
    output logic               tick_o,
    output logic               parked_o
);
    typedef struct packed {
        logic               en;
        logic [RATIO_W-1:0] field;
        logic [RATIO_W-1:0] cnt;
        logic               park;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [RATIO_W-1:0] lim;
    logic term;

    always_comb begin
        st_d = st_q;
        lim  = st_q.en ? st_q.field : '0;
        term = (st_q.cnt == lim);
        if (load) begin
            st_d.en    = pend_en;
            st_d.field = pend_field;
            st_d.cnt   = '0;
            st_d.park  = 1'b0;
        end else if (!st_q.park) begin
            if (term) begin
                st_d.cnt  = '0;
                st_d.park = sel;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        tick_o   = term && !st_q.park;
        parked_o = st_q.park;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pdb_regs.sv
module pdb_regs
    import pdb_pkg::*;
#(
    parameter int NUM_DIV = 8,
    parameter int RATIO_W = 9
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wen,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DATA_W-1:0]               wdata,
    input  logic                            busy,
    input  logic                            clr_chg,
    output logic [NUM_DIV-1:0]              pend_en,
    output logic [NUM_DIV-1:0][RATIO_W-1:0] pend_field,
    output logic [NUM_DIV-1:0]              align_o,
    output logic [NUM_DIV-1:0]              chg_o,
    output logic [DATA_W-1:0]               rdata
);
    typedef struct packed {
        logic [NUM_DIV-1:0]              en;
        logic [NUM_DIV-1:0][RATIO_W-1:0] field;
        logic [NUM_DIV-1:0]              align;
        logic [NUM_DIV-1:0]              chg;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        rdata = '0;
        for (int i = 0; i < NUM_DIV; i++) begin
            if (wen && addr == div_addr(i)) begin
                st_d.en[i]    = wdata[EN_BIT];
                st_d.field[i] = wdata[RATIO_W-1:0];
            end
            if (addr == div_addr(i)) begin
                rdata[EN_BIT]      = st_q.en[i];
                rdata[RATIO_W-1:0] = st_q.field[i];
            end
        end
        if (wen && !busy && addr == A_ALIGN) st_d.align = wdata[NUM_DIV-1:0];
        if (wen && !busy && addr == A_CHG)   st_d.chg   = wdata[NUM_DIV-1:0];
        if (clr_chg) st_d.chg = '0;
        if (addr == A_ALIGN) rdata[NUM_DIV-1:0] = st_q.align;
        if (addr == A_CHG)   rdata[NUM_DIV-1:0] = st_q.chg;
        if (addr == A_STAT)  rdata[0] = busy;
        pend_en    = st_q.en;
        pend_field = st_q.field;
        align_o    = st_q.align;
        chg_o      = st_q.chg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pdb_bank.sv
module pdb_bank
    import pdb_pkg::*;
#(
    parameter int NUM_DIV = 8,
    parameter int RATIO_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wen,
    input  logic [7:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic [NUM_DIV-1:0] div_en
);
    typedef struct packed {
        logic busy;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic [NUM_DIV-1:0]              pend_en;
    logic [NUM_DIV-1:0][RATIO_W-1:0] pend_field;
    logic [NUM_DIV-1:0]              align;
    logic [NUM_DIV-1:0]              chg;
    logic [NUM_DIV-1:0]              marked;
    logic [NUM_DIV-1:0]              parked;
    logic [NUM_DIV-1:0]              sel;
    logic [NUM_DIV-1:0]              load;
    logic                            busy;
    logic                            go_req;
    logic                            done;

    pdb_regs #(.NUM_DIV(NUM_DIV), .RATIO_W(RATIO_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wen        (reg_wen),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .busy       (busy),
        .clr_chg    (done),
        .pend_en    (pend_en),
        .pend_field (pend_field),
        .align_o    (align),
        .chg_o      (chg),
        .rdata      (reg_rdata)
    );

    always_comb begin
        st_d   = st_q;
        busy   = st_q.busy;
        marked = align & chg;
        go_req = reg_wen && (reg_addr == A_CMD) && reg_wdata[0] && !st_q.busy;
        done   = st_q.busy && (&(parked | ~marked));
        sel    = {NUM_DIV{st_q.busy}} & marked;
        load   = {NUM_DIV{done}} & marked;
        if (go_req)    st_d.busy = 1'b1;
        else if (done) st_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
        pdb_div #(.RATIO_W(RATIO_W)) u_div (
            .clk        (clk),
            .rst_n      (rst_n),
            .pend_en    (pend_en[g]),
            .pend_field (pend_field[g]),
            .sel        (sel[g]),
            .load       (load[g]),
            .tick_o     (div_en[g]),
            .parked_o   (parked[g])
        );
    end
endmodule

// File: rtl/pdb_bank_chk.sv
module pdb_bank_chk #(
    parameter int NUM_DIV = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic [NUM_DIV-1:0] marked,
    input logic [NUM_DIV-1:0] parked,
    input logic [NUM_DIV-1:0] align,
    input logic [NUM_DIV-1:0] chg,
    input logic [7:0]         reg_addr,
    input logic               stat_bit
);
    AST_STATUS_TRACKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 8'h3C) |-> (stat_bit == busy)); // R6
    AST_IDLE_NONE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (parked == '0)); // R7
    AST_PARK_ONLY_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((parked & ~marked) == '0)); // R8
    AST_CHG_CLEARED_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (chg == '0)); // R9
    AST_ALIGN_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(align)); // R10
    AST_CHG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(chg))); // R10
    AST_EMPTY_GO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && marked == '0) |=> !busy); // R11
endmodule

bind pdb_bank pdb_bank_chk #(.NUM_DIV(NUM_DIV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .marked   (marked),
    .parked   (parked),
    .align    (align),
    .chg      (chg),
    .reg_addr (reg_addr),
    .stat_bit (reg_rdata[0])
);

// File: tb/tb_pdb_bank.sv
module tb_pdb_bank;
    localparam int ND = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_wen;
    logic [7:0]    reg_addr;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;
    logic [ND-1:0] div_en;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    pdb_bank #(.NUM_DIV(ND), .RATIO_W(9)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .div_en(div_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle(input int maxc);
        int n = 0;
        reg_addr = 8'h3C;
        #1;
        while (reg_rdata[0] && n < maxc) begin
            chk(div_en[1] == 1'b1, "R8 unselected channel 1 keeps running while busy", div_en[1], 1);
            @(negedge clk);
            reg_addr = 8'h3C;
            #1;
            n++;
        end
        chk(reg_rdata[0] == 1'b0, "R6 status returns to idle", reg_rdata[0], 0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            chk(div_en == '1, "R1 strobes high every cycle after reset", div_en, 8'hFF);
        end
        rd(8'h3C, v); chk(v == 0, "R1 status idle after reset", v, 0);
        rd(8'h18, v); chk(v == 0, "R1 staged ratio zero after reset", v, 0);
        rd(8'h44, v); chk(v == 0, "R1 change mask zero after reset", v, 0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        logic [7:0] offs [ND] = '{8'h18, 8'h1C, 8'h20, 8'h60, 8'h64, 8'h68, 8'h6C, 8'h70};
        for (int i = 0; i < ND - 1; i++) wr(offs[i], 32'(i + 10));
        wr(8'h70, 32'hFFFF_FFFF);
        for (int i = 0; i < ND - 1; i++) begin
            rd(offs[i], v);
            chk(v == 32'(i + 10), "R5 staged ratio at its offset", v, i + 10);
        end
        rd(8'h70, v);
        chk(v == 32'h0000_81FF, "R4 readback keeps only enable and field", v, 32'h81FF);
        @(negedge clk); #1;
        chk(div_en == '1, "R4 staged write leaves strobes unchanged", div_en, 8'hFF);
    endtask

    task automatic t_go_aligned();
        logic [31:0] v;
        int bad0 = 0;
        int bad3 = 0;
        wr(8'h18, 32'h8003);
        wr(8'h60, 32'h8005);
        wr(8'h40, 32'h09);
        wr(8'h44, 32'h09);
        #1 chk(div_en[0] == 1'b1, "R4 channel 0 still divides by 1 before go", div_en[0], 1);
        wr(8'h38, 32'h1);
        reg_addr = 8'h3C;
        #1 chk(reg_rdata[0] == 1'b1, "R6 status busy after go", reg_rdata[0], 1);
        wait_idle(20);
        for (int k = 0; k < 24; k++) begin
            if (div_en[0] != ((k % 4) == 3)) bad0++;
            if (div_en[3] != ((k % 6) == 5)) bad3++;
            if (k == 11)
                chk(div_en[0] && div_en[3], "R7 selected channels strobe together at k=11",
                    {div_en[3], div_en[0]}, 3);
            @(negedge clk); #1;
        end
        chk(bad0 == 0, "R2 channel 0 strobes every 4 cycles from the load", bad0, 0);
        chk(bad3 == 0, "R7 channel 3 restarts at count 0 with period 6", bad3, 0);
        rd(8'h44, v); chk(v == 0, "R9 change mask cleared", v, 0);
        rd(8'h40, v); chk(v == 32'h09, "R9 align mask kept", v, 32'h09);
    endtask

    task automatic t_empty_go();
        int p0 = 0;
        wr(8'h1C, 32'h8001);
        wr(8'h38, 32'h1);
        reg_addr = 8'h3C;
        #1 chk(reg_rdata[0] == 1'b1, "R6 status busy for an empty go", reg_rdata[0], 1);
        @(negedge clk); #1;
        chk(reg_rdata[0] == 1'b0, "R11 empty go completes after one edge", reg_rdata[0], 0);
        for (int k = 0; k < 8; k++) begin
            chk(div_en[1] == 1'b1, "R8 unselected channel keeps old ratio", div_en[1], 1);
            if (div_en[0]) p0++;
            @(negedge clk); #1;
        end
        chk(p0 == 2, "R8 channel 0 keeps period 4", p0, 2);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        wr(8'h20, 32'h8028);
        wr(8'h40, 32'h04);
        wr(8'h44, 32'h04);
        wr(8'h38, 32'h1);
        wait_idle(20);
        wr(8'h20, 32'h8000);
        wr(8'h44, 32'h04);
        wr(8'h38, 32'h1);
        wr(8'h38, 32'h1);
        wr(8'h44, 32'hFF);
        wr(8'h40, 32'hFF);
        rd(8'h3C, v); chk(v[0] == 1'b1, "R10 still busy during long go", v[0], 1);
        rd(8'h44, v); chk(v == 32'h04, "R10 change write ignored while busy", v, 32'h04);
        rd(8'h40, v); chk(v == 32'h04, "R10 align write ignored while busy", v, 32'h04);
        wait_idle(80);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); reg_addr = 8'h3C; #1;
            chk(reg_rdata[0] == 1'b0, "R10 no second go queued", reg_rdata[0], 0);
            chk(div_en[2] == 1'b1, "R2 enabled field 0 strobes every cycle", div_en[2], 1);
        end
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        int p4 = 0;
        wr(8'h64, 32'h0007);
        wr(8'h40, 32'h10);
        wr(8'h44, 32'h10);
        wr(8'h38, 32'h1);
        wait_idle(20);
        for (int k = 0; k < 8; k++) begin
            if (div_en[4]) p4++;
            @(negedge clk); #1;
        end
        chk(p4 == 8, "R3 disabled channel strobes every cycle", p4, 8);
        rd(8'h64, v); chk(v == 32'h7, "R4 disabled word reads back", v, 7);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 50000) begin
            @(posedge clk);
            cyc++;
        end
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wen = 1'b0; reg_addr = 8'h00; reg_wdata = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_go_aligned();
        t_empty_go();
        t_busy_ignore();
        t_disabled();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule